// File: doc/BRIEF.md
# Odd/Even Pixel Pair Splitter

This block takes a stream of pixel words, one per input clock, and divides it into pairs so that a display link with two parallel halves can be driven at half the input rate. Every pixel carries 25 data bits plus horizontal sync, vertical sync and data-enable. In dual mode the first pixel of a pair is placed on port A and the second on port B. Both pixels are presented together with a one-cycle `pair_vld` strobe. Each port also has its pixel arranged as four 7-bit lane frames, and a 7-bit clock-lane pattern, ready for a serializer that sits outside this block.

Pairing locks on the first low-to-high transition of data-enable after reset or power-up. From then on, pairing alternates on every clock. A blanking run of odd length is reported on `blank_err`, but it does not shift the pairing back into step. The only way to realign is to pulse `pd_n` low and then high. When `dual_mode` is low, every pixel is passed to port A at the full rate.

Top module: `sp_pixel_splitter`

## Requirements
- R1: While `rst` is high or `pd_n` is low at a rising clock edge, the block ignores its data inputs. After that edge, `pair_vld`, `blank_err`, `a_pix`, `b_pix`, both lane buses and both clock-lane patterns are all zero, and the pairing lock is cleared.
- R2: A pixel is packed as {`pix_word[27:21]`, `pix_word[17:0]`, `hs`, `vs`, `de`}. Bits 27..3 hold the data, bit 2 holds hs, bit 1 holds vs and bit 0 holds de. `pix_word[20:18]` has no effect on any output.
- R3: In dual mode with no lock, nothing is paired until a cycle in which `de` is high and was low in the previous cycle. The pixel of that cycle is the odd pixel, and the pixel of the next cycle is the even pixel.
- R4: Once locked, pairing alternates odd/even on every cycle, whatever `de` does. This holds through blanking and through data-enable drops in the middle of a line.
- R5: In dual mode, one clock after the even pixel is sampled, `a_pix` shows the odd pixel and `b_pix` shows the even pixel, and `pair_vld` is high for exactly that one cycle. Both words then stay unchanged for two cycles.
- R6: In dual mode, a `de` rise that ends a run of `de`-low cycles of odd length pulses `blank_err` high for one cycle after the rising edge. This applies only to runs that began after lock. The pairing phase is not changed.
- R7: After `pd_n` returns high, pairing waits for the next `de` rise, as in R3. This brings pairing back into step after an odd blanking run.
- R8: With `dual_mode` low, every pixel appears on `a_pix` one clock after it is sampled, with `pair_vld` high. `b_pix` is zero and the lock is cleared.
- R9: Lane k of a port occupies bits [7k+6:7k] of its lane bus, and bit 0 of each lane is sent first. The serial order is data[17:0], hs, vs, de, data[24:18]. This places hs, vs and de at lane 2, bits 4 to 6.
- R10: After an edge without reset or power-down, `a_clk_lane` equals 7'b0001111, which is high for 4 bit times and low for 3. `b_clk_lane` takes the same value when the sampled `dual_mode` was high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down, active low; acts as a reset and resync |
| dual_mode | input | 1 | High: split into A/B pairs; low: all pixels on A |
| pix_word | input | 28 | Pixel data; bits 20:18 are not used |
| hs | input | 1 | Horizontal sync |
| vs | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| pair_vld | output | 1 | A/B words updated this cycle |
| blank_err | output | 1 | Odd-length blanking run just ended |
| a_pix | output | 28 | Odd pixel (port A) |
| b_pix | output | 28 | Even pixel (port B) |
| a_lanes | output | 28 | Port A lane frames, 4 x 7 bits |
| b_lanes | output | 28 | Port B lane frames, 4 x 7 bits |
| a_clk_lane | output | 7 | Port A clock-lane pattern |
| b_clk_lane | output | 7 | Port B clock-lane pattern |

## Verification
The stable-pair and strobe-spacing properties assume that `dual_mode` is held for at least two cycles around a pair. They also assume that `pd_n` and `rst` are low-active and high-active controls whose values are defined from time zero. The stimulus changes the mode only between scenarios, and keeps blanking runs even except in one directed run that is made odd on purpose. It toggles `pd_n` only while the data inputs carry arbitrary values, which checks that those values are ignored.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int DATA_W    = 25;
    localparam int LANES     = 4;
    localparam int LANE_BITS = 7;
    localparam int CLK_HIGH  = 4;
    localparam int PIX_W     = DATA_W + 3;
    localparam int FRAME_W   = LANES * LANE_BITS;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              hs;
        logic              vs;
        logic              de;
    } pix_t;

    typedef enum logic {PH_ODD = 1'b0, PH_EVEN = 1'b1} phase_t;

    function automatic pix_t pack_pix(input logic [PIX_W-1:0] w,
                                      input logic h, input logic v,
                                      input logic d);
        pix_t p;
        p.data = {w[27:21], w[17:0]};
        p.hs   = h;
        p.vs   = v;
        p.de   = d;
        return p;
    endfunction

    function automatic logic [LANE_BITS-1:0] clk_pattern();
        logic [LANE_BITS-1:0] pat;
        for (int i = 0; i < LANE_BITS; i++) pat[i] = (i < CLK_HIGH);
        return pat;
    endfunction
endpackage

// File: rtl/sp_lane_map.sv
module sp_lane_map
    import sp_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int L_BITS  = LANE_BITS,
    localparam int W      = N_LANES * L_BITS
) (
    input  pix_t         pix,
    output logic [W-1:0] lanes
);
    logic [W-1:0] serial;

    // serial order: low data, syncs and enable, then high data
    assign serial = {pix.data[DATA_W-1:18], pix.de, pix.vs, pix.hs, pix.data[17:0]};

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        assign lanes[k*L_BITS +: L_BITS] = serial[k*L_BITS +: L_BITS];
    end
endmodule

// File: rtl/sp_blank_mon.sv
module sp_blank_mon (
    input  logic clk,
    input  logic rst,
    input  logic dual,
    input  logic locked,
    input  logic de,
    output logic blank_err
);
    logic de_q;
    logic odd_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q      <= 1'b1;
            odd_q     <= 1'b0;
            armed_q   <= 1'b0;
            blank_err <= 1'b0;
        end else begin
            de_q      <= de;
            blank_err <= 1'b0;
            if (!dual) begin
                odd_q   <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (de && !de_q) begin
                    blank_err <= armed_q && odd_q;
                    odd_q     <= 1'b0;
                end else if (!de) begin
                    odd_q <= ~odd_q;
                end
                if (locked && !de && de_q) armed_q <= 1'b1;
            end
        end
    end

    // R6
    err_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        blank_err |-> ($past(de) && $past(dual)));

    // R6
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blank_err |=> !blank_err);
endmodule

// File: rtl/sp_pair_ctrl.sv
module sp_pair_ctrl
    import sp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dual,
    input  pix_t pix_in,
    output pix_t a_pix,
    output pix_t b_pix,
    output logic pair_vld,
    output logic locked
);
    phase_t phase_q;
    pix_t   hold_q;
    logic   de_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_ODD;
            hold_q   <= '0;
            a_pix    <= '0;
            b_pix    <= '0;
            pair_vld <= 1'b0;
            locked   <= 1'b0;
            de_q     <= 1'b1;
        end else begin
            de_q     <= pix_in.de;
            pair_vld <= 1'b0;
            if (!dual) begin
                a_pix    <= pix_in;
                b_pix    <= '0;
                pair_vld <= 1'b1;
                locked   <= 1'b0;
                phase_q  <= PH_ODD;
            end else if (!locked) begin
                if (pix_in.de && !de_q) begin
                    hold_q  <= pix_in;
                    locked  <= 1'b1;
                    phase_q <= PH_EVEN;
                end
            end else if (phase_q == PH_ODD) begin
                hold_q  <= pix_in;
                phase_q <= PH_EVEN;
            end else begin
                a_pix    <= hold_q;
                b_pix    <= pix_in;
                pair_vld <= 1'b1;
                phase_q  <= PH_ODD;
            end
        end
    end

    // R3
    lock_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(pix_in.de) && $past(dual)));

    // R5
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_vld && dual && $past(dual)) |=> !pair_vld);

    // R5
    pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_vld && dual && $past(dual)) |=> ($stable(a_pix) && $stable(b_pix)));
endmodule

// File: rtl/sp_pixel_splitter.sv
module sp_pixel_splitter
    import sp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pd_n,
    input  logic        dual_mode,
    input  logic [27:0] pix_word,
    input  logic        hs,
    input  logic        vs,
    input  logic        de,
    output logic        pair_vld,
    output logic        blank_err,
    output logic [27:0] a_pix,
    output logic [27:0] b_pix,
    output logic [27:0] a_lanes,
    output logic [27:0] b_lanes,
    output logic [6:0]  a_clk_lane,
    output logic [6:0]  b_clk_lane
);
    localparam logic [LANE_BITS-1:0] CLK_PAT = clk_pattern();

    logic hold_rst;
    logic locked;
    logic alive_q;
    logic dual_q;
    pix_t pix_in;
    pix_t port_pix [2];
    logic [FRAME_W-1:0] port_lanes [2];
    logic unused_bits;

    assign hold_rst    = rst | ~pd_n;
    assign pix_in      = pack_pix(pix_word, hs, vs, de);
    assign unused_bits = ^pix_word[20:18];

    sp_pair_ctrl i_pair (
        .clk      (clk),
        .rst      (hold_rst),
        .dual     (dual_mode),
        .pix_in   (pix_in),
        .a_pix    (port_pix[0]),
        .b_pix    (port_pix[1]),
        .pair_vld (pair_vld),
        .locked   (locked)
    );

    sp_blank_mon i_blank (
        .clk       (clk),
        .rst       (hold_rst),
        .dual      (dual_mode),
        .locked    (locked),
        .de        (de),
        .blank_err (blank_err)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        sp_lane_map i_map (
            .pix   (port_pix[p]),
            .lanes (port_lanes[p])
        );
    end

    always_ff @(posedge clk) begin
        if (hold_rst) begin
            alive_q <= 1'b0;
            dual_q  <= 1'b0;
        end else begin
            alive_q <= 1'b1;
            dual_q  <= dual_mode;
        end
    end

    assign a_pix      = port_pix[0];
    assign b_pix      = port_pix[1];
    assign a_lanes    = port_lanes[0];
    assign b_lanes    = port_lanes[1];
    assign a_clk_lane = alive_q ? CLK_PAT : '0;
    assign b_clk_lane = (alive_q && dual_q) ? CLK_PAT : '0;

    // R1
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> (!pair_vld && !blank_err && a_pix == '0 && b_pix == '0
                   && a_clk_lane == '0 && b_clk_lane == '0));

    // R9
    lane2_sync_chk: assert property (@(posedge clk) disable iff (hold_rst)
        (a_lanes[20:18] == {a_pix[0], a_pix[1], a_pix[2]}) && (b_lanes[27:21] == b_pix[27:21]));

    // R10
    clk_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (pd_n && !dual_mode) |=> (a_clk_lane == 7'b0001111 && b_clk_lane == '0));
endmodule

// File: tb/test_sp_pixel_splitter.sv
`timescale 1ns/1ps
module test_sp_pixel_splitter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_n = 1'b1;
    logic        dual_mode = 1'b1;
    logic [27:0] pix_word = '0;
    logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
    logic        pair_vld, blank_err;
    logic [27:0] a_pix, b_pix, a_lanes, b_lanes;
    logic [6:0]  a_clk_lane, b_clk_lane;

    int checks = 0;
    int failures = 0;
    string scn = "R1";
    bit done = 1'b0;

    // reference model state
    bit        m_lock, m_even, m_deq, m_odd, m_armed, m_alive, m_dual, m_vld, m_err;
    bit [27:0] m_hold, m_a, m_b;

    always #4 clk = ~clk;

    sp_pixel_splitter i_sp_pixel_splitter (
        .clk(clk), .rst(rst), .pd_n(pd_n), .dual_mode(dual_mode),
        .pix_word(pix_word), .hs(hs), .vs(vs), .de(de),
        .pair_vld(pair_vld), .blank_err(blank_err),
        .a_pix(a_pix), .b_pix(b_pix), .a_lanes(a_lanes), .b_lanes(b_lanes),
        .a_clk_lane(a_clk_lane), .b_clk_lane(b_clk_lane)
    );

    function automatic bit [27:0] exp_pix(bit [27:0] w, bit h, bit v, bit d);
        bit [24:0] data;
        data = {w[27:21], w[17:0]};
        return {data, h, v, d};
    endfunction

    function automatic bit [27:0] exp_lanes(bit [27:0] p);
        bit [27:0] r;
        for (int i = 0; i < 28; i++) begin
            if (i < 18)       r[i] = p[3 + i];
            else if (i == 18) r[i] = p[2];
            else if (i == 19) r[i] = p[1];
            else if (i == 20) r[i] = p[0];
            else              r[i] = p[i];
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, bit [27:0] act, bit [27:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit [27:0] p;
        bit rise, nerr;
        if (rst || !pd_n) begin
            m_lock = 0; m_even = 0; m_deq = 1; m_odd = 0; m_armed = 0;
            m_alive = 0; m_dual = 0; m_vld = 0; m_err = 0;
            m_hold = '0; m_a = '0; m_b = '0;
        end else begin
            p = exp_pix(pix_word, hs, vs, de);
            rise = de && !m_deq;
            nerr = 0;
            if (!dual_mode) begin
                m_odd = 0; m_armed = 0;
            end else begin
                if (rise) begin nerr = m_armed && m_odd; m_odd = 0; end
                else if (!de) m_odd = !m_odd;
                if (m_lock && !de && m_deq) m_armed = 1;
            end
            m_vld = 0;
            if (!dual_mode) begin
                m_a = p; m_b = '0; m_vld = 1; m_lock = 0; m_even = 0;
            end else if (!m_lock) begin
                if (rise) begin m_hold = p; m_lock = 1; m_even = 1; end
            end else if (!m_even) begin
                m_hold = p; m_even = 1;
            end else begin
                m_a = m_hold; m_b = p; m_vld = 1; m_even = 0;
            end
            m_deq = de; m_err = nerr; m_alive = 1; m_dual = dual_mode;
        end
    endtask

    task automatic compare();
        bit [6:0] ea, eb;
        ea = m_alive ? 7'b0001111 : 7'b0;
        eb = (m_alive && m_dual) ? 7'b0001111 : 7'b0;
        chk(a_pix === m_a, scn, "a_pix", a_pix, m_a);
        chk(b_pix === m_b, scn, "b_pix", b_pix, m_b);
        chk(pair_vld === m_vld, "R5", "pair_vld", {27'b0, pair_vld}, {27'b0, m_vld});
        chk(blank_err === m_err, "R6", "blank_err", {27'b0, blank_err}, {27'b0, m_err});
        chk(a_lanes === exp_lanes(m_a), "R9", "a_lanes", a_lanes, exp_lanes(m_a));
        chk(b_lanes === exp_lanes(m_b), "R9", "b_lanes", b_lanes, exp_lanes(m_b));
        chk(a_clk_lane === ea, "R10", "a_clk_lane", {21'b0, a_clk_lane}, {21'b0, ea});
        chk(b_clk_lane === eb, "R10", "b_clk_lane", {21'b0, b_clk_lane}, {21'b0, eb});
    endtask

    // one clock: drive at the falling edge, model at the rising edge, compare at the next fall
    task automatic cyc(bit pd, bit mode, bit d);
        pd_n = pd; dual_mode = mode; de = d;
        pix_word = $urandom; hs = $urandom; vs = $urandom;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(bit d, int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, d);
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_step();
        @(negedge clk);
        // R1: reset state
        scn = "R1";
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, i[0]);
        rst = 1'b0;
        // R3: nothing pairs before the first de rise, then lock
        scn = "R3";
        run(1'b1, 3);
        run(1'b0, 4);
        run(1'b1, 10);
        // R4: even blanking and a mid-line enable drop
        scn = "R4";
        run(1'b0, 6);
        run(1'b1, 5);
        run(1'b0, 2);
        run(1'b1, 7);
        run(1'b0, 4);
        // R6: odd blanking flags an error, phase kept
        scn = "R6";
        run(1'b1, 8);
        run(1'b0, 3);
        run(1'b1, 8);
        run(1'b0, 4);
        run(1'b1, 6);
        // R1: power-down pulse with toggling inputs ignored
        scn = "R1";
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, i[0]);
        // R7: realign on the next rise
        scn = "R7";
        run(1'b1, 3);
        run(1'b0, 4);
        run(1'b1, 10);
        run(1'b0, 2);
        // R8: single mode, full rate on A
        scn = "R8";
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, $urandom_range(0, 1));
        // R2: unused bits toggled alone
        scn = "R2";
        for (int i = 0; i < 6; i++) begin
            pd_n = 1'b1; dual_mode = 1'b0; de = 1'b1; hs = 1'b1; vs = 1'b0;
            pix_word = {7'h55, i[2:0], 18'h2AAAA};
            @(posedge clk); model_step(); @(negedge clk); compare();
        end
        // R4: random dual frames with even blanking
        scn = "R4";
        run(1'b0, 4);
        for (int l = 0; l < 200; l++) begin
            run(1'b1, $urandom_range(1, 24));
            run(1'b0, 2 * $urandom_range(1, 5));
        end
        // R7: power-down while enable is high, then recover
        scn = "R7";
        run(1'b1, 3);
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b1, 1'b1);
        run(1'b1, 4);
        run(1'b0, 2);
        run(1'b1, 9);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule